// File: doc/BRIEF.md
# Serial Byte Link (8N1 Transmitter and Receiver)

This block moves bytes over a single-wire asynchronous serial line in each direction, eight data bits per frame with no parity and one stop bit. A shared parameter gives the number of system clock cycles in one bit period. Both directions use this value.

The transmit side takes a byte through a valid/ready handshake and drives the serial output. The output stays high while idle. The receive side passes its serial input through a two-stage synchroniser. It then waits for a low level on an idle line, samples each data bit at the middle of its bit period and presents the byte with a strobe that lasts one cycle. Each frame restarts the receive timing, so a far end whose bit rate differs slightly from nominal is still received correctly.

Top module: `uart_link`

## Requirements
- R1: After reset, and at any time the transmitter is ready, `txd` is high, `tx_ready` is high and `rx_valid` is low.
- R2: A byte is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both high. From the next cycle on, `tx_ready` is low and `txd` drives the start bit, which is low.
- R3: The transmitted frame starts in the cycle after acceptance. It is made of 10 bit periods of exactly C clock cycles each: a low start bit, then data bit 0 (least significant) through data bit 7, then a high stop bit.
- R4: `tx_ready` rises again exactly 10*C cycles after the accepting edge, once the stop bit has been driven for a full C cycles.
- R5: While `tx_ready` is low, `tx_valid` and `tx_data` are ignored. The frame in progress and the byte later received are unchanged.
- R6: The receiver takes the first low level on the synchronised input while idle as a start bit. It samples data bit k at 1.5*C + k*C cycles after that point. It presents the 8 bits, least significant first, on `rx_data` with `rx_valid` high for exactly one cycle.
- R7: After a start bit, the receiver does not look for a new start bit until 9.5*C cycles have passed. A byte whose most significant bit is 0 therefore never yields an extra byte, and two `rx_valid` strobes are never closer than 9.5*C cycles.
- R8: Frames whose bit period is 2% longer or 2% shorter than C cycles are received without error.
- R9: Frames sent back to back, with the next start bit directly after the previous stop bit, are all received in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |

## Verification
The checker assumes that a byte offered on the handshake stays offered until it is taken. It also assumes that frames reaching `rxd` have an idle or stop interval of at least 9.5 bit periods between start edges, so the strobe spacing property can only fail through a receiver fault. The bench keeps to this. It drives `tx_valid` only from a task that waits for ready, and pulses it while busy only to show that it is ignored. Its own off-rate frames use periods within 2% of nominal and always end with a full stop bit. The loopback path sends back-to-back frames, each 10*C cycles long, which is above the assumed minimum spacing.

// File: rtl/uart_pkg.sv
package uart_pkg;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;

    // Frame as shifted onto the line, bit 0 first: start, data LSB first, stop.
    function automatic logic [FRAME_BITS-1:0] make_frame(input logic [DATA_BITS-1:0] b);
        return {1'b1, b, 1'b0};
    endfunction
endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 valid,
    output logic                 ready,
    output logic                 line
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] TICK_LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [3:0]    BIT_LAST  = 4'(FRAME_BITS - 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic [CW-1:0]         tick;
        logic [3:0]            bitn;
        logic                  busy;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (valid) begin
                st_d.shreg = make_frame(data);
                st_d.busy  = 1'b1;
                st_d.tick  = '0;
                st_d.bitn  = '0;
            end
        end else if (st_q.tick == TICK_LAST) begin
            st_d.tick  = '0;
            st_d.shreg = {1'b1, st_q.shreg[FRAME_BITS-1:1]};
            if (st_q.bitn == BIT_LAST) st_d.busy = 1'b0;
            else                       st_d.bitn = st_q.bitn + 4'd1;
        end else begin
            st_d.tick = st_q.tick + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shreg <= '1;
            st_q.tick  <= '0;
            st_q.bitn  <= '0;
            st_q.busy  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line  = st_q.shreg[0];
    assign ready = !st_q.busy;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid
);
    localparam int EW = $clog2(10 * CLKS_PER_BIT + 1);
    localparam logic [EW-1:0] FIRST_SAMPLE = EW'((3 * CLKS_PER_BIT) / 2);
    localparam logic [EW-1:0] STEP         = EW'(CLKS_PER_BIT);
    localparam logic [EW-1:0] REARM_AT     = EW'((19 * CLKS_PER_BIT) / 2 - 1);

    typedef struct packed {
        logic                 active;
        logic [EW-1:0]        elapsed;
        logic [EW-1:0]        next_at;
        logic [2:0]           nbits;
        logic [DATA_BITS-1:0] shreg;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (!st_q.active) begin
            if (!line) begin
                st_d.active  = 1'b1;
                st_d.elapsed = EW'(1);
                st_d.next_at = FIRST_SAMPLE;
                st_d.nbits   = '0;
            end
        end else begin
            st_d.elapsed = st_q.elapsed + EW'(1);
            if (st_q.elapsed == st_q.next_at) begin
                st_d.shreg   = {line, st_q.shreg[DATA_BITS-1:1]};
                st_d.next_at = st_q.next_at + STEP;
                st_d.nbits   = st_q.nbits + 3'd1;
                if (st_q.nbits == 3'd7) begin
                    st_d.data  = {line, st_q.shreg[DATA_BITS-1:1]};
                    st_d.valid = 1'b1;
                end
            end
            if (st_q.elapsed == REARM_AT) st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active  <= 1'b0;
            st_q.elapsed <= '0;
            st_q.next_at <= '0;
            st_q.nbits   <= '0;
            st_q.shreg   <= '0;
            st_q.data    <= '0;
            st_q.valid   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data  = st_q.data;
    assign valid = st_q.valid;
endmodule

// File: rtl/uart_link.sv
module uart_link
    import uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic [7:0] rx_data,
    output logic       rx_valid
);
    logic rxd_s;

    uart_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .data (tx_data),
        .valid(tx_valid),
        .ready(tx_ready),
        .line (txd)
    );

    uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .line (rxd_s),
        .data (rx_data),
        .valid(rx_valid)
    );
endmodule

// File: rtl/uart_link_chk.sv
module uart_link_chk #(
    parameter int CLKS_PER_BIT = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic rx_valid
);
    localparam logic [31:0] FRAME_CYC = 32'(10 * CLKS_PER_BIT);
    localparam logic [31:0] MIN_GAP   = 32'((19 * CLKS_PER_BIT) / 2);

    logic [31:0] busy_cnt;
    logic [31:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            gap_cnt  <= MIN_GAP;
        end else begin
            if (tx_valid && tx_ready) busy_cnt <= '0;
            else if (!tx_ready)       busy_cnt <= busy_cnt + 32'd1;
            if (rx_valid)                   gap_cnt <= 32'd1;
            else if (gap_cnt != 32'hFFFF)   gap_cnt <= gap_cnt + 32'd1;
        end
    end

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    // R2
    start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && !txd));

    // R4
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> (busy_cnt == FRAME_CYC));

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (gap_cnt >= MIN_GAP));
endmodule

bind uart_link uart_link_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .txd     (txd),
    .rx_valid(rx_valid)
);

// File: tb/uart_link_test.sv
`timescale 1ns/1ps
module uart_link_test;
    localparam int  C      = 16;
    localparam real CLK_NS = 20.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, txd, rxd, rx_valid;
    logic [7:0] rx_data;
    logic       line_sel = 1'b0;
    logic       bench_line = 1'b1;

    assign rxd = line_sel ? bench_line : txd;

    uart_link #(.CLKS_PER_BIT(C)) uut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_data(rx_data),
        .rx_valid(rx_valid)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: R6 data and single strobe, R7 no spurious byte, R9 order
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                m_chk++;
                if (prev_valid) begin
                    m_fail++;
                    $display("FAIL R6: strobe longer than one cycle actual 1 expected 0");
                end
                if (exp_q.size() == 0) begin
                    m_fail++;
                    $display("FAIL R7: unexpected byte actual %0h expected none", rx_data);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (rx_data !== e) begin
                        m_fail++;
                        $display("FAIL R9: received byte actual %0h expected %0h", rx_data, e);
                    end
                end
            end
            prev_valid = rx_valid;
        end
    end

    // Sends one byte through the transmitter and checks the line bit by bit.
    task automatic send_byte(input logic [7:0] b, input bit poke);
        logic [9:0] f;
        f = {1'b1, b, 1'b0};
        while (!tx_ready) @(negedge clk);
        if (!line_sel) exp_q.push_back(b);
        tx_data  = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(!tx_ready && !txd, "R2", {tx_ready, txd}, 0);
        repeat (C / 2) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            check(txd == f[k], "R3", txd, f[k]);
            if (poke && k == 2) begin
                tx_data  = ~b;          // R5: offered while busy
                tx_valid = 1'b1;
            end
            if (poke && k == 7) tx_valid = 1'b0;
            if (k < 9) repeat (C) @(negedge clk);
        end
        repeat (C / 2 - 1) @(negedge clk);
        check(!tx_ready, "R4", tx_ready, 0);
        @(negedge clk);
        check(tx_ready, "R4", tx_ready, 1);
    endtask

    // R8: drive the receiver directly with a bit period off nominal
    task automatic drive_line(input logic [7:0] b, input real bit_ns);
        exp_q.push_back(b);
        bench_line = 1'b0;
        #(bit_ns);
        for (int i = 0; i < 8; i++) begin
            bench_line = b[i];
            #(bit_ns);
        end
        bench_line = 1'b1;
        #(bit_ns);
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 n_chk + m_chk, n_fail + m_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_ready && txd && !rx_valid, "R1", {tx_ready, txd, rx_valid}, 3'b110);

        // loopback, several patterns; R7 with zero MSB bytes
        send_byte(8'h55, 1'b0);
        send_byte(8'h7F, 1'b0);
        send_byte(8'h00, 1'b0);
        send_byte(8'h80, 1'b1);   // R5 poke while busy
        send_byte(8'hFF, 1'b0);
        send_byte(8'h01, 1'b0);
        send_byte(8'hA6, 1'b1);   // R5 again
        repeat (3 * C) @(negedge clk);
        check(tx_ready && txd, "R1", {tx_ready, txd}, 2'b11);
        check(exp_q.size() == 0, "R9", exp_q.size(), 0);

        // R8 slow and fast far end
        line_sel = 1'b1;
        repeat (2 * C) @(negedge clk);
        drive_line(8'h3C, C * CLK_NS * 1.02);
        drive_line(8'h7E, C * CLK_NS * 1.02);
        drive_line(8'hC3, C * CLK_NS * 0.98);
        drive_line(8'h0F, C * CLK_NS * 0.98);
        repeat (3 * C) @(negedge clk);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        line_sel = 1'b0;
        repeat (2 * C) @(negedge clk);
        check(!rx_valid, "R7", rx_valid, 0);

        if (!done) begin
            done = 1;
            report();
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end
endmodule